// File: doc/BRIEF.md
# Posted Column Command Latency Pipeline

This block is a clock-cycle model of how a DRAM device schedules posted column commands. A single-rate command port carries row-open, row-close, read and write commands, each with a bank number. Three static configuration inputs set the additive latency, the CAS latency and the minimum row-open-to-column delay. Each bank keeps its own open flag and a count of the cycles since its row was opened. A column command may therefore be checked against the timing of its own bank only.

A column command to an open bank enters a shift-register delay line. An internal column strobe is raised once the additive latency has run out. The read-data-valid and write-capture windows open at the read latency (additive plus CAS latency) and at the write latency (additive latency plus one). Each window lasts two single-rate cycles, which stands for a four-beat double-rate burst. Several column commands can be in flight at once. Three one-cycle error flags are also produced: a column command issued too early for the configured latency, a column command to a bank with no open row, and a write whose data window would follow read data on the same bank without enough bus turnaround time.

The block is meant for a memory-controller testbench or a device model. It lets the command timing of a controller be checked against posted-column rules without a data path.

Top module: `posted_cas_pipe`

## Requirements
- R1: After a synchronous reset, every output is low, every bank is closed and no command is in flight.
- R2: A column command accepted in cycle t to an open bank raises `col_strobe_o` for one cycle in cycle t+AL+1. That cycle carries the command's direction on `col_wr_o` (1 = write) and its bank on `col_bank_o`.
- R3: A read accepted in cycle t to an open bank drives `rd_valid_o` high in cycles t+AL+CL and t+AL+CL+1, where CL is at least 1. This holds up to the largest configurable latency.
- R4: A write accepted in cycle t to an open bank drives `wr_cap_o` high in cycles t+AL+1 and t+AL+2.
- R5: Each bank counts the cycles elapsed since its own most recent row-open. A row-open in cycle a gives an elapsed value of t-a in cycle t, held at the configurable maximum. A column command is timed only against the counter of the bank it names.
- R6: A column command whose elapsed value is below the configured delay raises `early_err_o` in the following cycle. The one exception is an elapsed value of exactly one less than the delay with AL non-zero, which is legal. A flagged command is still forwarded.
- R7: A read or write to a bank that has not been opened since reset, or that was closed by a row-close, raises `closed_err_o` in the following cycle. It produces no strobe and no data window, and it raises neither of the other two flags.
- R8: A write accepted in cycle w to a bank whose most recent forwarded read was accepted in cycle r is flagged on `turn_err_o` in cycle w+1 when w+AL+1 < r+AL+CL+4. That is, fewer than two idle cycles separate the last read cycle from the first write cycle. The write is still forwarded. Reads to other banks do not count.
- R9: Column commands accepted in consecutive cycles, to the same or different banks, each produce their own strobe and data window. The windows are merged onto the outputs.
- R10: The command code on `cmd_i` is 0 = idle, 1 = row-open, 2 = read, 3 = write, 4 = row-close. Codes 5 to 7 act as idle. A row-open never raises an error flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 3 | Command code (see R10) |
| bank_i | input | BANK_W (2) | Bank addressed by the command |
| cfg_al_i | input | AL_W (3) | Additive latency, 0 to AL_MAX, static |
| cfg_cl_i | input | CL_W (4) | CAS latency, 1 to CL_MAX, static |
| cfg_trcd_i | input | TRCD_W (5) | Minimum row-open-to-column delay in cycles, static |
| col_strobe_o | output | 1 | Internal column strobe |
| col_wr_o | output | 1 | Strobe direction, 1 = write |
| col_bank_o | output | BANK_W (2) | Strobe bank, zero when no strobe |
| rd_valid_o | output | 1 | Read data valid window |
| wr_cap_o | output | 1 | Write data capture window |
| early_err_o | output | 1 | Column command issued too early |
| closed_err_o | output | 1 | Column command to a closed bank |
| turn_err_o | output | 1 | Read-to-write turnaround too short |

## Verification
A wrong bank counter shows up as an early flag that is wrongly raised or missing, one cycle after the next column command to that bank. A fault on the per-bank open flag shows up the same way on the closed flag or as a missing strobe. A slipped tap or a corrupted stage in the delay line moves or drops the strobe and the data windows. This becomes visible between AL+1 and AL+CL+1 cycles after the command, so the bench checks every output on every cycle against its own timeline of expected events. A stale turnaround guard is seen only when a write to the same bank follows. For that reason the scenarios place writes exactly at, and one cycle inside, the turnaround limit.

// File: rtl/pcas_pkg.sv
`timescale 1ns/1ps
package pcas_pkg;

    localparam int unsigned CMD_W = 3;

    localparam logic [CMD_W-1:0] CMD_IDLE = 3'd0;
    localparam logic [CMD_W-1:0] CMD_OPEN = 3'd1;
    localparam logic [CMD_W-1:0] CMD_RD   = 3'd2;
    localparam logic [CMD_W-1:0] CMD_WR   = 3'd3;
    localparam logic [CMD_W-1:0] CMD_SHUT = 3'd4;

    // One stage of the column delay line
    typedef struct packed {
        logic vld;
        logic wr;
    } slot_t;

    // Result of checking the command presented this cycle
    typedef struct packed {
        logic fwd;
        logic early;
        logic closed;
        logic turn;
    } verdict_t;

    function automatic logic is_column(input logic [CMD_W-1:0] c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/pcas_bank_timer.sv
`timescale 1ns/1ps
module pcas_bank_timer #(
    parameter int unsigned TRCD_MAX = 31,
    parameter int unsigned G_W      = 5,
    localparam int unsigned TRCD_W  = $clog2(TRCD_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req_i,
    input  logic              shut_req_i,
    input  logic              rd_load_i,
    input  logic [G_W-1:0]    guard_load_i,
    output logic              open_o,
    output logic [TRCD_W-1:0] elapsed_o,
    output logic [G_W-1:0]    guard_o
);
    logic              open_q;
    logic [TRCD_W-1:0] cnt_q;
    logic [G_W-1:0]    guard_q;
    logic [G_W-1:0]    guard_dec;

    assign guard_dec = (guard_q == '0) ? '0 : guard_q - G_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            cnt_q   <= '0;
            guard_q <= '0;
        end else begin
            if (open_req_i) begin
                open_q <= 1'b1;
            end else if (shut_req_i) begin
                open_q <= 1'b0;
            end

            if (open_req_i) begin
                cnt_q <= TRCD_W'(1);
            end else if (open_q && (cnt_q != TRCD_W'(TRCD_MAX))) begin
                cnt_q <= cnt_q + TRCD_W'(1);
            end

            if (rd_load_i && (guard_load_i > guard_dec)) begin
                guard_q <= guard_load_i;
            end else begin
                guard_q <= guard_dec;
            end
        end
    end

    assign open_o    = open_q;
    assign elapsed_o = cnt_q;
    assign guard_o   = guard_q;
endmodule

// File: rtl/pcas_issue_check.sv
`timescale 1ns/1ps
module pcas_issue_check
    import pcas_pkg::*;
#(
    parameter int unsigned TRCD_W = 5,
    parameter int unsigned G_W    = 5
) (
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              open_i,
    input  logic [TRCD_W-1:0] elapsed_i,
    input  logic [G_W-1:0]    guard_i,
    input  logic              al_nonzero_i,
    input  logic [TRCD_W-1:0] trcd_i,
    input  logic [G_W-1:0]    wl_i,
    output verdict_t          verdict_o
);
    logic col;
    logic one_short;

    assign col       = is_column(cmd_i);
    assign one_short = (trcd_i != '0) && (elapsed_i == trcd_i - TRCD_W'(1));

    always_comb begin
        verdict_o        = '0;
        verdict_o.closed = col && !open_i;
        verdict_o.fwd    = col && open_i;
        verdict_o.early  = verdict_o.fwd && (elapsed_i < trcd_i)
                           && !(al_nonzero_i && one_short);
        verdict_o.turn   = verdict_o.fwd && (cmd_i == CMD_WR) && (wl_i < guard_i);
    end
endmodule

// File: rtl/pcas_delay_line.sv
`timescale 1ns/1ps
module pcas_delay_line
    import pcas_pkg::*;
#(
    parameter int unsigned DEPTH  = 20,
    parameter int unsigned BANK_W = 2,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld_i,
    input  logic              in_wr_i,
    input  logic [BANK_W-1:0] in_bank_i,
    input  logic [IDX_W-1:0]  tap_stb_i,
    input  logic [IDX_W-1:0]  tap_rd_i,
    output logic              stb_o,
    output logic              stb_wr_o,
    output logic [BANK_W-1:0] stb_bank_o,
    output logic              rd_valid_o,
    output logic              wr_cap_o
);
    slot_t             sr   [DEPTH];
    logic [BANK_W-1:0] bk   [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr[0] <= '0;
            bk[0] <= '0;
        end else begin
            sr[0] <= '{vld: in_vld_i, wr: in_wr_i};
            bk[0] <= in_bank_i;
        end
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                sr[s] <= '0;
                bk[s] <= '0;
            end else begin
                sr[s] <= sr[s-1];
                bk[s] <= bk[s-1];
            end
        end
    end

    slot_t s_stb, s_wr2, s_rd1, s_rd2;
    logic [IDX_W-1:0] tap_wr2, tap_rd1;

    assign tap_wr2 = tap_stb_i + IDX_W'(1);
    assign tap_rd1 = tap_rd_i - IDX_W'(1);

    assign s_stb = sr[tap_stb_i];
    assign s_wr2 = sr[tap_wr2];
    assign s_rd1 = sr[tap_rd1];
    assign s_rd2 = sr[tap_rd_i];

    assign stb_o      = s_stb.vld;
    assign stb_wr_o   = s_stb.vld && s_stb.wr;
    assign stb_bank_o = s_stb.vld ? bk[tap_stb_i] : '0;
    assign wr_cap_o   = (s_stb.vld && s_stb.wr) || (s_wr2.vld && s_wr2.wr);
    assign rd_valid_o = (s_rd1.vld && !s_rd1.wr) || (s_rd2.vld && !s_rd2.wr);
endmodule

// File: rtl/posted_cas_pipe.sv
`timescale 1ns/1ps
module posted_cas_pipe
    import pcas_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned AL_MAX    = 4,
    parameter int unsigned CL_MAX    = 15,
    parameter int unsigned TRCD_MAX  = 31,
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS),
    localparam int unsigned AL_W     = $clog2(AL_MAX + 1),
    localparam int unsigned CL_W     = $clog2(CL_MAX + 1),
    localparam int unsigned TRCD_W   = $clog2(TRCD_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [AL_W-1:0]   cfg_al_i,
    input  logic [CL_W-1:0]   cfg_cl_i,
    input  logic [TRCD_W-1:0] cfg_trcd_i,
    output logic              col_strobe_o,
    output logic              col_wr_o,
    output logic [BANK_W-1:0] col_bank_o,
    output logic              rd_valid_o,
    output logic              wr_cap_o,
    output logic              early_err_o,
    output logic              closed_err_o,
    output logic              turn_err_o
);
    localparam int unsigned DEPTH     = AL_MAX + CL_MAX + 1;
    localparam int unsigned IDX_W     = $clog2(DEPTH);
    localparam int unsigned GUARD_MAX = AL_MAX + CL_MAX + 3;
    localparam int unsigned G_W       = $clog2(GUARD_MAX + 1);

    // Latency taps and turnaround constants
    logic [IDX_W-1:0] tap_stb, tap_rd;
    logic [G_W-1:0]   guard_load, wl_g;

    assign tap_stb    = IDX_W'(cfg_al_i);
    assign tap_rd     = IDX_W'(cfg_al_i) + IDX_W'(cfg_cl_i);
    assign guard_load = G_W'(tap_rd) + G_W'(3);
    assign wl_g       = G_W'(cfg_al_i) + G_W'(1);

    // Per-bank state
    logic [NUM_BANKS-1:0] bank_open;
    logic [TRCD_W-1:0]    bank_elapsed [NUM_BANKS];
    logic [G_W-1:0]       bank_guard   [NUM_BANKS];
    verdict_t             verdict;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = (bank_i == BANK_W'(b));

        pcas_bank_timer #(
            .TRCD_MAX (TRCD_MAX),
            .G_W      (G_W)
        ) u_timer (
            .clk          (clk),
            .rst          (rst),
            .open_req_i   (hit && (cmd_i == CMD_OPEN)),
            .shut_req_i   (hit && (cmd_i == CMD_SHUT)),
            .rd_load_i    (hit && verdict.fwd && (cmd_i == CMD_RD)),
            .guard_load_i (guard_load),
            .open_o       (bank_open[b]),
            .elapsed_o    (bank_elapsed[b]),
            .guard_o      (bank_guard[b])
        );
    end

    pcas_issue_check #(
        .TRCD_W (TRCD_W),
        .G_W    (G_W)
    ) u_check (
        .cmd_i        (cmd_i),
        .open_i       (bank_open[bank_i]),
        .elapsed_i    (bank_elapsed[bank_i]),
        .guard_i      (bank_guard[bank_i]),
        .al_nonzero_i (cfg_al_i != '0),
        .trcd_i       (cfg_trcd_i),
        .wl_i         (wl_g),
        .verdict_o    (verdict)
    );

    pcas_delay_line #(
        .DEPTH  (DEPTH),
        .BANK_W (BANK_W)
    ) u_line (
        .clk        (clk),
        .rst        (rst),
        .in_vld_i   (verdict.fwd),
        .in_wr_i    (cmd_i == CMD_WR),
        .in_bank_i  (bank_i),
        .tap_stb_i  (tap_stb),
        .tap_rd_i   (tap_rd),
        .stb_o      (col_strobe_o),
        .stb_wr_o   (col_wr_o),
        .stb_bank_o (col_bank_o),
        .rd_valid_o (rd_valid_o),
        .wr_cap_o   (wr_cap_o)
    );

    // Error flags: one-cycle pulses after the offending command
    always_ff @(posedge clk) begin
        if (rst) begin
            early_err_o  <= 1'b0;
            closed_err_o <= 1'b0;
            turn_err_o   <= 1'b0;
        end else begin
            early_err_o  <= verdict.early;
            closed_err_o <= verdict.closed;
            turn_err_o   <= verdict.turn;
        end
    end
endmodule

// File: rtl/pcas_checker.sv
`timescale 1ns/1ps
module pcas_checker
    import pcas_pkg::*;
#(
    parameter int unsigned NB     = 4,
    parameter int unsigned BANK_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [CMD_W-1:0]  cmd_i,
    input logic [BANK_W-1:0] bank_i,
    input logic [NB-1:0]     bank_open,
    input logic              col_strobe_o,
    input logic              col_wr_o,
    input logic              rd_valid_o,
    input logic              wr_cap_o,
    input logic              early_err_o,
    input logic              closed_err_o,
    input logic              turn_err_o
);
    // R1
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(col_strobe_o || rd_valid_o || wr_cap_o
                         || early_err_o || closed_err_o || turn_err_o));

    // R2
    a_r2_write_strobe_opens_window: assert property (@(posedge clk) disable iff (rst)
        (col_strobe_o && col_wr_o) |-> wr_cap_o);

    // R3
    a_r3_read_window_two_cycles: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid_o) |=> rd_valid_o);

    // R4
    a_r4_write_window_two_cycles: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_cap_o) |=> wr_cap_o);

    // R6
    a_r6_early_needs_column: assert property (@(posedge clk) disable iff (rst)
        early_err_o |-> $past(is_column(cmd_i)));

    // R7
    a_r7_closed_bank_flagged: assert property (@(posedge clk) disable iff (rst)
        (is_column(cmd_i) && !bank_open[bank_i]) |=> closed_err_o);

    // R7
    a_r7_closed_is_exclusive: assert property (@(posedge clk) disable iff (rst)
        closed_err_o |-> (!early_err_o && !turn_err_o));

    // R8
    a_r8_turn_needs_write: assert property (@(posedge clk) disable iff (rst)
        turn_err_o |-> $past(cmd_i == CMD_WR));

    // R10
    a_r10_open_raises_no_flag: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_OPEN) |=> !(early_err_o || closed_err_o || turn_err_o));
endmodule

bind posted_cas_pipe pcas_checker #(
    .NB     (NUM_BANKS),
    .BANK_W (BANK_W)
) u_pcas_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_i        (cmd_i),
    .bank_i       (bank_i),
    .bank_open    (bank_open),
    .col_strobe_o (col_strobe_o),
    .col_wr_o     (col_wr_o),
    .rd_valid_o   (rd_valid_o),
    .wr_cap_o     (wr_cap_o),
    .early_err_o  (early_err_o),
    .closed_err_o (closed_err_o),
    .turn_err_o   (turn_err_o)
);

// File: tb/sim_posted_cas_pipe.sv
`timescale 1ns/1ps
module sim_posted_cas_pipe;
    localparam int NB     = 4;
    localparam int TRCD_M = 31;
    localparam int RING   = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd_i = 3'd0;
    logic [1:0] bank_i = 2'd0;
    logic [2:0] cfg_al = 3'd0;
    logic [3:0] cfg_cl = 4'd1;
    logic [4:0] cfg_trcd = 5'd1;
    logic       col_strobe_o, col_wr_o, rd_valid_o, wr_cap_o;
    logic       early_err_o, closed_err_o, turn_err_o;
    logic [1:0] col_bank_o;

    always #2.5 clk = ~clk;

    posted_cas_pipe u0 (
        .clk (clk), .rst (rst), .cmd_i (cmd_i), .bank_i (bank_i),
        .cfg_al_i (cfg_al), .cfg_cl_i (cfg_cl), .cfg_trcd_i (cfg_trcd),
        .col_strobe_o (col_strobe_o), .col_wr_o (col_wr_o), .col_bank_o (col_bank_o),
        .rd_valid_o (rd_valid_o), .wr_cap_o (wr_cap_o), .early_err_o (early_err_o),
        .closed_err_o (closed_err_o), .turn_err_o (turn_err_o)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    rst_q   = 1'b1;
    bit    done    = 1'b0;
    string tag     = "R1";

    // Expected-event timeline, indexed by cycle modulo RING
    bit e_stb [RING];
    bit e_swr [RING];
    int e_sbk [RING];
    bit e_rd  [RING];
    bit e_wr  [RING];
    bit e_ear [RING];
    bit e_clo [RING];
    bit e_trn [RING];

    bit m_open  [NB];
    int m_act   [NB];
    int m_clear [NB];

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s cycle %0d: actual %0d expected %0d", req, tag, what, cyc, act, exp);
        end
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        int t, el, al, cl, tr, b;
        t  = cyc;
        al = int'(cfg_al); cl = int'(cfg_cl); tr = int'(cfg_trcd);
        b  = int'(bank_i);
        rst_q = rst;
        if (rst) begin
            for (int i = 0; i < RING; i++) begin
                e_stb[i] = 0; e_swr[i] = 0; e_sbk[i] = 0; e_rd[i] = 0;
                e_wr[i] = 0; e_ear[i] = 0; e_clo[i] = 0; e_trn[i] = 0;
            end
            for (int i = 0; i < NB; i++) begin
                m_open[i] = 0; m_act[i] = 0; m_clear[i] = 0;
            end
        end else begin
            case (cmd_i)
                3'd1: begin m_open[b] = 1; m_act[b] = t; end
                3'd4: m_open[b] = 0;
                3'd2, 3'd3: begin
                    if (!m_open[b]) begin
                        e_clo[(t+1)%RING] = 1;
                    end else begin
                        el = t - m_act[b];
                        if (el > TRCD_M) el = TRCD_M;
                        if (el < tr && !(al > 0 && el == tr - 1)) e_ear[(t+1)%RING] = 1;
                        e_stb[(t+al+1)%RING] = 1;
                        e_swr[(t+al+1)%RING] = (cmd_i == 3'd3);
                        e_sbk[(t+al+1)%RING] = b;
                        if (cmd_i == 3'd2) begin
                            e_rd[(t+al+cl)%RING]   = 1;
                            e_rd[(t+al+cl+1)%RING] = 1;
                            if (t + al + cl + 4 > m_clear[b]) m_clear[b] = t + al + cl + 4;
                        end else begin
                            if (t + al + 1 < m_clear[b]) e_trn[(t+1)%RING] = 1;
                            e_wr[(t+al+1)%RING] = 1;
                            e_wr[(t+al+2)%RING] = 1;
                        end
                    end
                end
                default: ;
            endcase
        end
        cyc = t + 1;
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int k;
        k = cyc % RING;
        if (!rst_q && !done) begin
            chk("R2", "strobe", {7'd0, col_strobe_o}, {7'd0, e_stb[k]});
            if (e_stb[k]) begin
                chk("R2", "strobe dir", {7'd0, col_wr_o}, {7'd0, e_swr[k]});
                chk("R2", "strobe bank", {6'd0, col_bank_o}, 8'(e_sbk[k]));
            end
            chk("R3", "rd_valid", {7'd0, rd_valid_o}, {7'd0, e_rd[k]});
            chk("R4", "wr_cap", {7'd0, wr_cap_o}, {7'd0, e_wr[k]});
            chk("R6", "early", {7'd0, early_err_o}, {7'd0, e_ear[k]});
            chk("R7", "closed", {7'd0, closed_err_o}, {7'd0, e_clo[k]});
            chk("R8", "turn", {7'd0, turn_err_o}, {7'd0, e_trn[k]});
        end
        e_stb[k] = 0; e_swr[k] = 0; e_sbk[k] = 0; e_rd[k] = 0;
        e_wr[k] = 0; e_ear[k] = 0; e_clo[k] = 0; e_trn[k] = 0;
    end

    task automatic step(input logic [2:0] c, input logic [1:0] b);
        @(negedge clk);
        cmd_i  = c;
        bank_i = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 2'd0);
    endtask

    task automatic restart(input int al, input int cl, input int tr);
        @(negedge clk);
        rst = 1'b1; cmd_i = 3'd0; bank_i = 2'd0;
        cfg_al = 3'(al); cfg_cl = 4'(cl); cfg_trcd = 5'(tr);
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        restart(1, 7, 9);
        @(negedge clk);
        @(negedge clk);
        // R1: outputs quiet after reset
        chk("R1", "outputs after reset",
            {1'b0, col_strobe_o, rd_valid_o, wr_cap_o, early_err_o, closed_err_o, turn_err_o, col_wr_o},
            8'd0);

        // R2 R3 R4 R8: AL=1, delay 9, CL=7, read one cycle before the delay
        tag = "R2";
        step(3'd1, 2'd0); idle(7);
        step(3'd2, 2'd0);           // read, elapsed 8
        idle(3); step(3'd3, 2'd0);  // write 4 cycles later: turnaround too short
        idle(20);
        tag = "R8";
        step(3'd2, 2'd0); idle(8);
        step(3'd3, 2'd0);           // w+2 = r+11, one inside the limit: flagged
        step(3'd3, 2'd0);           // w+2 = r+12, at the limit: legal
        idle(3); step(3'd3, 2'd1);  // other bank closed
        idle(25);

        // R6: AL=0 makes the one-short read illegal
        restart(0, 7, 9);
        tag = "R6";
        step(3'd1, 2'd1); idle(7);
        step(3'd2, 2'd1);           // elapsed 8: flagged
        step(3'd2, 2'd1);           // elapsed 9: legal
        idle(20);
        restart(2, 5, 9);
        step(3'd1, 2'd2); idle(6);
        step(3'd2, 2'd2);           // elapsed 7 with AL=2: flagged
        step(3'd2, 2'd2);           // elapsed 8 with AL=2: legal
        idle(20);

        // R5: per-bank timing, counter saturation
        restart(0, 3, 9);
        tag = "R5";
        step(3'd1, 2'd3); idle(40);
        step(3'd1, 2'd2);
        step(3'd3, 2'd3);           // bank 3 saturated: legal
        step(3'd2, 2'd2);           // bank 2 elapsed 2: flagged
        idle(15);

        // R7: never opened, and closed by row-close
        tag = "R7";
        step(3'd2, 2'd1);
        step(3'd1, 2'd1); idle(10);
        step(3'd4, 2'd1);
        step(3'd3, 2'd1);
        step(3'd2, 2'd1);
        idle(15);

        // R9: back-to-back traffic, largest latency for R3
        restart(4, 15, 2);
        tag = "R9";
        step(3'd1, 2'd0); step(3'd1, 2'd1); step(3'd1, 2'd2); idle(2);
        step(3'd2, 2'd0); step(3'd2, 2'd1); step(3'd3, 2'd2);
        step(3'd2, 2'd2); step(3'd3, 2'd0); step(3'd2, 2'd0);
        idle(40);
        tag = "R3";
        step(3'd2, 2'd1); idle(30);

        // R10: undefined codes act as idle
        restart(1, 2, 3);
        tag = "R10";
        step(3'd1, 2'd0); idle(5);
        step(3'd5, 2'd0); step(3'd6, 2'd0); step(3'd7, 2'd0);
        step(3'd5, 2'd3); step(3'd7, 2'd1);
        idle(12);
        step(3'd2, 2'd0); idle(12);

        done = 1'b1;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule